// File: doc/BRIEF.md
# Write-Through Data Cache with Per-Longword Valid Bits

This block is a 256-byte direct-mapped data cache placed between a processor load/store port and a memory bus. It holds 16 lines of four 32-bit longwords. The untranslated address is used for both index and tag, so the block needs no translation stage in front of it. Each longword carries its own valid bit, so a line may be only partly present. A lookup hits only when the line tag matches and the addressed longword is valid.

A read miss is refilled in one of two ways. If the memory side reports `mem_burst_ok` high when the miss is accepted, the block issues one burst request. It then takes four data beats: the first is the requested longword and the rest follow in wrap-around order within the line. Otherwise the block fetches only the requested longword. The processor gets its data as soon as the first beat arrives, even while a burst is still running. Every write goes to memory, so the cache never holds data that memory lacks. A write hit also updates the cached copy. With `wr_alloc` high, a write miss installs the written longword. A single-cycle `inv_all` pulse drops every valid bit.

The request channel and the read-response channel are valid/ready. The block accepts one request at a time: `cpu_req_ready` is high only when no memory transaction is in progress and no read response is waiting. A response holds `cpu_rsp_valid` and its data stable until `cpu_rsp_ready`. On the memory side, `mem_req_valid` and its fields hold stable until `mem_req_ready`. Refill beats on `mem_rsp_valid` are always taken; there is no back-pressure on them.

Top module: `wt_dcache`

## Requirements
- R1: Address bits [3:2] pick the longword, bits [7:4] pick one of 16 lines, and bits [31:8] are the tag. A read hits only when the line tag equals the address tag and that longword's valid bit is set.
- R2: A read hit raises `cpu_rsp_valid` in the cycle after acceptance with the cached longword, and issues no memory request.
- R3: A read miss accepted while `mem_burst_ok` is low issues exactly one memory read with `mem_req_burst` low and takes one beat. Only the requested longword becomes valid, so the other longwords of that line still miss.
- R4: A read miss accepted while `mem_burst_ok` is high issues exactly one memory read with `mem_req_burst` high and takes four beats. Beat k is written to longword (requested + k) mod 4, and every longword of the line then hits.
- R5: On a refill, the response carries the first beat's data and becomes valid in the cycle after that beat, before the remaining burst beats are taken.
- R6: Every accepted write produces exactly one memory write carrying the same longword address and data.
- R7: A write hit updates the cached longword, and a later read of it hits with the new data.
- R8: With `wr_alloc` low, a write miss leaves the cache unchanged, so a later read of that address misses.
- R9: With `wr_alloc` high, a write miss installs the written longword as valid. If the line held a different tag, its other longwords become invalid.
- R10: A cycle with `inv_all` high clears every valid bit, so every later read misses until it is refilled.
- R11: After reset `cpu_req_ready` is high and both `cpu_rsp_valid` and `mem_req_valid` are low. A pending response and a pending memory request each hold valid and data stable until accepted, and no new request is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request accepted when high with valid |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address (untranslated) |
| cpu_req_wdata | input | 32 | Write longword |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_ready | input | 1 | Processor takes read data |
| cpu_rsp_rdata | output | 32 | Read longword |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_burst | output | 1 | Read asks for a four-beat wrapping burst |
| mem_req_addr | output | 32 | Longword-aligned address |
| mem_req_wdata | output | 32 | Write longword |
| mem_rsp_valid | input | 1 | Refill beat valid |
| mem_rsp_data | input | 32 | Refill beat data |
| mem_burst_ok | input | 1 | Memory can serve bursts; sampled when a miss is accepted |
| wr_alloc | input | 1 | Write misses install the longword |
| inv_all | input | 1 | Clear all valid bits this cycle |

## Verification
The hardest states to reach from the ports are partly valid lines whose tag has just changed, and a response that becomes visible while burst beats are still arriving. A long pseudo-random sequence mixes reads, writes with and without allocation, flushes and single or burst refills over four aliasing tags. It also changes memory behind the cache, so a wrong hit returns stale data. The memory model adds request stalls and gaps between beats. That stretches the window in which the first-beat response is checked against the count of beats already taken.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDREQ = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRREQ = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/wt_dcache_array.sv
module wt_dcache_array #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 24,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [WSEL_W-1:0] lk_word,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [WORDS-1:0]  vld_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES][WORDS];
  logic [LINES-1:0]  line_any;

  assign lk_hit  = vld_q[lk_idx][lk_word] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = dat_q[lk_idx][lk_word];

  // A write to a line under a new tag starts that line over with one valid word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
    end else if (inv_all) begin
      for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= ((tag_q[wr_idx] == wr_tag) ? vld_q[wr_idx] : '0)
                       | (WORDS'(1) << wr_word);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]          <= wr_tag;
      dat_q[wr_idx][wr_word] <= wr_data;
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_any
    assign line_any[l] = |vld_q[l];
  end

  a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (line_any == '0));
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W,
  localparam int LWA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic              mem_req_burst,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_burst_ok,
  input  logic              wr_alloc,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [WSEL_W-1:0] lk_word,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WSEL_W-1:0] wr_word,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  ctl_state_t        st_q;
  logic [LWA_W-1:0]  lwa_q;
  logic [DATA_W-1:0] wdata_q;
  logic              burst_q;
  logic [WSEL_W-1:0] beat_q;
  logic              rsp_pend_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              acc;
  logic [LWA_W-1:0]  req_lwa;
  logic              unused_low;

  assign req_lwa    = cpu_req_addr[ADDR_W-1:OFF_W];
  assign unused_low = ^cpu_req_addr[OFF_W-1:0];

  assign lk_word = req_lwa[WSEL_W-1:0];
  assign lk_idx  = req_lwa[WSEL_W +: IDX_W];
  assign lk_tag  = req_lwa[LWA_W-1 -: TAG_W];

  assign cpu_req_ready = (st_q == ST_IDLE) && !rsp_pend_q;
  assign acc           = cpu_req_valid && cpu_req_ready;
  assign cpu_rsp_valid = rsp_pend_q;
  assign cpu_rsp_rdata = rsp_data_q;

  assign mem_req_valid = (st_q == ST_RDREQ) || (st_q == ST_WRREQ);
  assign mem_req_we    = (st_q == ST_WRREQ);
  assign mem_req_burst = (st_q == ST_RDREQ) && burst_q;
  assign mem_req_addr  = {lwa_q, {OFF_W{1'b0}}};
  assign mem_req_wdata = wdata_q;

  // Array write: refill beats, or write hit / allocating write miss at acceptance.
  always_comb begin
    wr_en   = acc && cpu_req_we && (lk_hit || wr_alloc);
    wr_idx  = lk_idx;
    wr_word = lk_word;
    wr_tag  = lk_tag;
    wr_data = cpu_req_wdata;
    if (st_q == ST_FILL && mem_rsp_valid) begin
      wr_en   = 1'b1;
      wr_idx  = lwa_q[WSEL_W +: IDX_W];
      wr_word = lwa_q[WSEL_W-1:0] + beat_q;
      wr_tag  = lwa_q[LWA_W-1 -: TAG_W];
      wr_data = mem_rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      lwa_q      <= '0;
      wdata_q    <= '0;
      burst_q    <= 1'b0;
      beat_q     <= '0;
      rsp_pend_q <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      if (cpu_rsp_valid && cpu_rsp_ready) rsp_pend_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (acc) begin
          lwa_q   <= req_lwa;
          wdata_q <= cpu_req_wdata;
          burst_q <= mem_burst_ok;
          if (cpu_req_we) begin
            st_q <= ST_WRREQ;
          end else if (lk_hit) begin
            rsp_pend_q <= 1'b1;
            rsp_data_q <= lk_data;
          end else begin
            st_q <= ST_RDREQ;
          end
        end
        ST_RDREQ: if (mem_req_ready) begin
          st_q   <= ST_FILL;
          beat_q <= '0;
        end
        ST_FILL: if (mem_rsp_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == '0) begin
            rsp_pend_q <= 1'b1;
            rsp_data_q <= mem_rsp_data;
          end
          if (!burst_q || beat_q == WSEL_W'(WORDS - 1)) st_q <= ST_IDLE;
        end
        ST_WRREQ: if (mem_req_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                        && $stable(mem_req_we) && $stable(mem_req_burst));
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata));
  a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cpu_req_we |=> mem_req_valid && mem_req_we && mem_req_wdata == $past(cpu_req_wdata));
  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cpu_req_we && lk_hit |=> cpu_rsp_valid && !mem_req_valid);
  a_r5_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) && mem_rsp_valid && (beat_q == '0)
      |=> cpu_rsp_valid && cpu_rsp_rdata == $past(mem_rsp_data));
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic              mem_req_burst,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_burst_ok,
  input  logic              wr_alloc,
  input  logic              inv_all
);
  logic [IDX_W-1:0]  lk_idx, wr_idx;
  logic [WSEL_W-1:0] lk_word, wr_word;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [DATA_W-1:0] lk_data, wr_data;
  logic              lk_hit, wr_en;

  wt_dcache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_burst(mem_req_burst), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_burst_ok(mem_burst_ok), .wr_alloc(wr_alloc),
    .lk_idx(lk_idx), .lk_word(lk_word), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  wt_dcache_array #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_idx(lk_idx), .lk_word(lk_word), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_tag(wr_tag), .wr_data(wr_data)
  );
endmodule

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b1;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_we, mem_req_burst;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_burst_ok = 1'b0, wr_alloc = 1'b0, inv_all = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wt_dcache u_wt_dcache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_burst(mem_req_burst), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_burst_ok(mem_burst_ok), .wr_alloc(wr_alloc), .inv_all(inv_all)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int stall_n = 0, gap_n = 0;
  logic [31:0] bmem [1024];

  // expected cache contents (addresses kept below 4 KB, tag = bits [11:8])
  logic [3:0]  ref_tag [16];
  logic [3:0]  ref_vld [16];
  logic [31:0] ref_dat [16][4];

  int          req_cnt = 0, beat_cnt = 0;
  logic        lr_we = 1'b0, lr_burst = 1'b0;
  logic [31:0] lr_addr = '0, lr_wd = '0;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      req_cnt  <= req_cnt + 1;
      lr_we    <= mem_req_we;
      lr_burst <= mem_req_burst;
      lr_addr  <= mem_req_addr;
      lr_wd    <= mem_req_wdata;
    end
    if (mem_rsp_valid) beat_cnt <= beat_cnt + 1;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: optional stall before ready, wrapping beats with optional gaps
  initial begin
    logic [31:0] ra, rw;
    logic rwe, rb;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (stall_n) @(negedge clk);
        mem_req_ready = 1'b1;
        ra = mem_req_addr; rwe = mem_req_we; rb = mem_req_burst; rw = mem_req_wdata;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (rwe) bmem[ra[11:2]] = rw;
        else begin
          for (int b = 0; b < (rb ? 4 : 1); b++) begin
            if (b != 0) begin
              mem_rsp_valid = 1'b0;
              repeat (gap_n) @(negedge clk);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = bmem[{ra[11:4], 2'(ra[3:2] + 2'(b))}];
            @(negedge clk);
          end
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  function automatic bit ref_hit(input logic [31:0] a);
    return ref_vld[a[7:4]][a[3:2]] && ref_tag[a[7:4]] == a[11:8];
  endfunction

  task automatic ref_install(input logic [31:0] a, input logic [31:0] d);
    if (ref_tag[a[7:4]] != a[11:8]) ref_vld[a[7:4]] = 4'b0000;
    ref_tag[a[7:4]] = a[11:8];
    ref_vld[a[7:4]][a[3:2]] = 1'b1;
    ref_dat[a[7:4]][a[3:2]] = d;
  endtask

  task automatic do_read(input logic [31:0] a, input int hold, input string rq);
    bit exp_hit, exp_burst;
    logic [31:0] exp_d, got;
    int r0, b0;
    exp_hit   = ref_hit(a);
    exp_burst = mem_burst_ok && !exp_hit;
    exp_d     = exp_hit ? ref_dat[a[7:4]][a[3:2]] : bmem[a[11:2]];
    r0 = req_cnt; b0 = beat_cnt;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
    if (hold > 0) cpu_rsp_ready = 1'b0;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    got = cpu_rsp_rdata;
    chk(got == exp_d, {rq, " R1 read data"}, got, exp_d);
    if (exp_hit)
      chk(req_cnt == r0, "R2 hit issues no memory request", 32'(req_cnt - r0), 0);
    else
      chk(beat_cnt - b0 == 1, "R5 response after first beat", 32'(beat_cnt - b0), 1);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(cpu_rsp_valid && cpu_rsp_rdata == got && !cpu_req_ready,
          "R11 response held", {30'b0, cpu_rsp_valid, cpu_req_ready}, 32'h2);
    end
    cpu_rsp_ready = 1'b1;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    if (!exp_hit) begin
      chk(req_cnt - r0 == 1 && !lr_we && lr_burst == exp_burst,
          exp_burst ? "R4 one burst read" : "R3 one single read",
          {lr_burst, 31'(req_cnt - r0)}, {exp_burst, 31'd1});
      chk(beat_cnt - b0 == (exp_burst ? 4 : 1), exp_burst ? "R4 four beats" : "R3 one beat",
          32'(beat_cnt - b0), exp_burst ? 4 : 1);
      if (exp_burst) begin
        for (int w = 0; w < 4; w++) ref_install({a[31:4], 2'(w), 2'b00}, bmem[{a[11:4], 2'(w)}]);
      end else ref_install(a, exp_d);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    bit exp_hit;
    int r0;
    exp_hit = ref_hit(a);
    r0 = req_cnt;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
    while (!cpu_req_ready) @(negedge clk);
    chk(req_cnt - r0 == 1 && lr_we, "R6 one memory write", 32'(req_cnt - r0), 1);
    chk(lr_addr == {a[31:2], 2'b00} && lr_wd == d, "R6 write address and data", lr_wd, d);
    if (exp_hit) ref_dat[a[7:4]][a[3:2]] = d;
    else if (wr_alloc) ref_install(a, d);
  endtask

  task automatic do_inv();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int l = 0; l < 16; l++) ref_vld[l] = 4'b0000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 32'(checks), 32'(0));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] a;
    int r0;
    for (int i = 0; i < 1024; i++) bmem[i] = 32'h9E37_0000 ^ (32'(i) * 32'h0001_0101);
    for (int l = 0; l < 16; l++) begin ref_vld[l] = 4'b0000; ref_tag[l] = 4'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready && !cpu_rsp_valid && !mem_req_valid, "R11 reset state",
        {29'b0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 32'h4);

    // R3: single-longword refill leaves neighbours invalid
    mem_burst_ok = 1'b0;
    do_read(32'h014, 0, "R3");
    do_read(32'h010, 0, "R3");
    do_read(32'h014, 0, "R2");
    // R4 / R5: wrapping burst starting mid-line, with beat gaps
    mem_burst_ok = 1'b1; gap_n = 2; stall_n = 2;
    do_read(32'h0E8, 0, "R4");
    for (int w = 0; w < 4; w++) do_read(32'h0E0 + 32'(w * 4), 0, "R4");
    gap_n = 0; stall_n = 0;
    // R7: write hit updates cache
    do_write(32'h0E4, 32'hCAFE_0001);
    do_read(32'h0E4, 0, "R7");
    // R8: non-allocating write miss
    wr_alloc = 1'b0;
    r0 = req_cnt;
    do_write(32'h330, 32'h1234_5678);
    do_read(32'h330, 0, "R8");
    chk(req_cnt - r0 == 2, "R8 read after write miss goes to memory", 32'(req_cnt - r0), 2);
    // R9: allocating write with tag change drops old words of the line
    do_read(32'h048, 0, "R9");
    wr_alloc = 1'b1;
    do_write(32'h344, 32'hA110_C8ED);
    r0 = req_cnt;
    do_read(32'h344, 0, "R9");
    chk(req_cnt == r0, "R9 allocated word hits", 32'(req_cnt - r0), 0);
    do_read(32'h048, 0, "R9");
    chk(req_cnt - r0 == 1, "R9 old tag words dropped", 32'(req_cnt - r0), 1);
    // R11: response held under back-pressure
    do_read(32'h0E0, 3, "R11");
    // R10: invalidate all
    do_inv();
    r0 = req_cnt;
    do_read(32'h0EC, 0, "R10");
    do_read(32'h014, 0, "R10");
    chk(req_cnt - r0 == 2, "R10 reads miss after invalidate", 32'(req_cnt - r0), 2);

    // pseudo-random sweep over four aliasing tags
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 1500; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      mem_burst_ok = lf[12];
      wr_alloc     = lf[13];
      stall_n      = int'(lf[15:14]) & 1;
      gap_n        = int'(lf[16]);
      a = {20'b0, 2'b00, lf[1:0], lf[7:4], lf[9:8], 2'b00};
      case (lf[19:17])
        3'd0, 3'd1, 3'd2, 3'd3: do_read(a, 0, "R1");
        3'd4, 3'd5:             do_write(a, lf ^ 32'h5A5A_0F0F);
        3'd6:                   bmem[a[11:2]] = ~lf;
        default:                if (lf[22:20] == 3'd0) do_inv(); else do_read(a, 0, "R10");
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule